// File: doc/BRIEF.md
# Width-Packing Card Data FIFO Engine

This block carries the payload of block transfers between a processor bus and a memory card. A 32-byte transmit queue is filled by bus writes and drained byte by byte to the card. A 32-byte receive queue is filled byte by byte from the card and emptied by bus reads. A single bus access can move 1, 2 or 4 bytes. Several queue bytes are packed into one access, and the earliest byte always occupies the most significant lane of the accessed field.

A transfer begins with a one-cycle start pulse. The pulse captures the direction and loads a byte counter with block count times block length. The engine then trades one byte per cycle with the card over a byte-wide valid/ready stream until the counter is exhausted. After that it goes idle and pulses its completion outputs. The service request outputs tell software or a DMA engine when the queues need attention. An abort input, driven for example by a clock stop or a fresh configuration write, drops everything at once.

Top module: `card_fifo_engine`

## Requirements
- R1: After reset, `busy`, `tx_req`, `rx_req`, `data_done`, `prog_done`, `card_out_valid` and `card_in_ready` are all 0.
- R2: A `start` pulse empties both queues, latches `xfer_write` (1 = toward the card, 0 = from the card) and loads the byte counter with `blk_len` × `blk_cnt`. Exactly that many bytes then cross the card stream.
- R3: `bus_size` selects the access width N: 0 gives 1 byte, 1 gives 2 bytes, 2 and 3 give 4 bytes. A bus write pushes the N-byte field of `bus_wdata` starting from its most significant lane, bits [8N-1:8N-8]. Lanes above the field are ignored.
- R4: A bus write pushes only as many bytes as the transmit queue has room for at the start of the cycle. Bytes offered beyond 32 held bytes are discarded.
- R5: A bus read pops up to N bytes. The first popped byte appears in the most significant lane of the N-byte field of `bus_rdata`. Lanes not filled because the queue ran empty, and all lanes above the field, read as zero.
- R6: The receive queue never holds more than 32 bytes. `card_in_ready` is low while it is full.
- R7: At most one byte per cycle moves on the card stream, only in the latched direction, and only while bytes remain. `card_out_valid` requires a non-empty transmit queue.
- R8: When the counter reaches zero the engine drops `busy` and pulses `data_done` for one cycle. `prog_done` pulses with it only in write direction.
- R9: `tx_req` is high while a write-direction transfer is busy with bytes remaining, and low otherwise.
- R10: `rx_req` is set in a cycle that stores a card byte and cleared by a bus read. A store in the same cycle as a read wins.
- R11: `abort` returns the engine to idle within one cycle, empties both queues and clears `rx_req`. A later bus read returns zero.
- R12: A start with a zero product completes on the following clock edge, with `data_done` (and `prog_done` in write direction) high in the cycle after `busy` was first seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a data phase |
| abort | input | 1 | Stop the transfer and empty both queues |
| xfer_write | input | 1 | Direction latched at start: 1 toward card, 0 from card |
| blk_len | input | 12 | Bytes per block |
| blk_cnt | input | 16 | Number of blocks |
| bus_rd | input | 1 | Bus read of the receive queue |
| bus_wr | input | 1 | Bus write to the transmit queue |
| bus_size | input | 2 | Access width code |
| bus_wdata | input | 32 | Write data, first byte in the top lane of the field |
| bus_rdata | output | 32 | Read data for the current read access |
| card_out_data | output | 8 | Byte toward the card |
| card_out_valid | output | 1 | Byte toward the card is valid |
| card_out_ready | input | 1 | Card accepts the byte |
| card_in_data | input | 8 | Byte from the card |
| card_in_valid | input | 1 | Byte from the card is valid |
| card_in_ready | output | 1 | Engine accepts the byte |
| busy | output | 1 | Data phase in progress |
| tx_req | output | 1 | Transmit queue needs service |
| rx_req | output | 1 | Receive queue holds fresh data |
| data_done | output | 1 | One-cycle completion pulse |
| prog_done | output | 1 | One-cycle write completion pulse |

## Verification
The embedded properties watch the queue occupancy bounds and the card handshake on every cycle. They check that a card byte never moves while idle or with no bytes left, and never flows in both directions at once. They also check the single-cycle shape of the completion pulse and that abort leaves the receive queue empty. The byte ordering of packed accesses, the dropping of excess write bytes, the exact byte count per transfer and the zero-length timing depend on data values across many cycles. Only the bench scenarios show these, by comparing the card stream and the read data with sequences computed in the bench.

// File: rtl/cfe_pkg.sv
package cfe_pkg;

    // Bus access width codes; the two top codes both select a full word.
    typedef enum logic [1:0] {
        ACC_BYTE  = 2'd0,
        ACC_HALF  = 2'd1,
        ACC_WORD  = 2'd2,
        ACC_WORD2 = 2'd3
    } acc_size_e;

    localparam int FULL_LANES = 4;

    function automatic logic [2:0] lanes_of(input logic [1:0] code);
        case (acc_size_e'(code))
            ACC_BYTE: return 3'd1;
            ACC_HALF: return 3'd2;
            default:  return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/cfe_tx_fifo.sv
module cfe_tx_fifo #(
    parameter  int DEPTH = 32,
    parameter  int LANES = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1,
    localparam int LW    = $clog2(LANES) + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               bus_wr,
    input  logic [LW-1:0]      wr_bytes,
    input  logic [LANES*8-1:0] wdata,
    input  logic               pop,
    output logic [7:0]         head,
    output logic [CNT_W-1:0]   count
);
    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] cnt, room, want, npush;

    assign room  = CNT_W'(DEPTH) - cnt;
    assign want  = bus_wr ? CNT_W'(wr_bytes) : '0;
    assign npush = (want > room) ? room : want;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            wptr <= wptr + PTR_W'(npush);
            rptr <= rptr + PTR_W'(pop);
            cnt  <= cnt + npush - CNT_W'(pop);
        end
    end

    // Lane N-1 of the field is the first byte queued.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (CNT_W'(i) < npush)
                mem[wptr + PTR_W'(i)] <= wdata[(int'(wr_bytes) - 1 - i) * 8 +: 8];
        end
    end

    assign head  = mem[rptr];
    assign count = cnt;

    AST_TX_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop |-> (cnt != '0)); // R7
    AST_TX_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DEPTH)); // R4
endmodule

// File: rtl/cfe_rx_fifo.sv
module cfe_rx_fifo #(
    parameter  int DEPTH = 32,
    parameter  int LANES = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1,
    localparam int LW    = $clog2(LANES) + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               push,
    input  logic [7:0]         din,
    input  logic               bus_rd,
    input  logic [LW-1:0]      rd_bytes,
    output logic [LANES*8-1:0] rdata,
    output logic [CNT_W-1:0]   count
);
    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] cnt, want, npop;

    assign want = bus_rd ? CNT_W'(rd_bytes) : '0;
    assign npop = (want > cnt) ? cnt : want;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            wptr <= wptr + PTR_W'(push);
            rptr <= rptr + PTR_W'(npop);
            cnt  <= cnt - npop + CNT_W'(push);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= din;
    end

    // Oldest byte lands in the top lane of the accessed field.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < LANES; i++) begin
            if (CNT_W'(i) < npop)
                rdata[(int'(rd_bytes) - 1 - i) * 8 +: 8] = mem[rptr + PTR_W'(i)];
        end
    end

    assign count = cnt;

    AST_RX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> (cnt < CNT_W'(DEPTH))); // R6
    AST_RX_FLUSHED: assert property (@(posedge clk) disable iff (rst)
        flush |=> (cnt == '0)); // R11
endmodule

// File: rtl/cfe_byte_counter.sv
module cfe_byte_counter #(
    parameter  int LEN_W = 12,
    parameter  int NUM_W = 16,
    localparam int TOT_W = LEN_W + NUM_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort,
    input  logic [LEN_W-1:0] blk_len,
    input  logic [NUM_W-1:0] blk_cnt,
    input  logic             step,
    output logic             active,
    output logic [TOT_W-1:0] remaining,
    output logic             done
);
    logic [TOT_W-1:0] nxt;
    assign nxt = remaining - TOT_W'(step);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            active    <= 1'b0;
            remaining <= '0;
            done      <= 1'b0;
        end else if (start) begin
            active    <= 1'b1;
            remaining <= TOT_W'(blk_len) * TOT_W'(blk_cnt);
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (active) begin
                remaining <= nxt;
                if (nxt == '0) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    AST_STEP_WHILE_LEFT: assert property (@(posedge clk) disable iff (rst)
        step |-> (active && remaining != '0)); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !active); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
endmodule

// File: rtl/card_fifo_engine.sv
module card_fifo_engine
    import cfe_pkg::*;
#(
    parameter  int DEPTH = 32,
    parameter  int LEN_W = 12,
    parameter  int NUM_W = 16,
    localparam int LANES = FULL_LANES,
    localparam int DW    = LANES * 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1,
    localparam int LW    = $clog2(LANES) + 1,
    localparam int TOT_W = LEN_W + NUM_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort,
    input  logic             xfer_write,
    input  logic [LEN_W-1:0] blk_len,
    input  logic [NUM_W-1:0] blk_cnt,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [1:0]       bus_size,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic [7:0]       card_out_data,
    output logic             card_out_valid,
    input  logic             card_out_ready,
    input  logic [7:0]       card_in_data,
    input  logic             card_in_valid,
    output logic             card_in_ready,
    output logic             busy,
    output logic             tx_req,
    output logic             rx_req,
    output logic             data_done,
    output logic             prog_done
);
    logic             flush, dir_wr, active, done, left;
    logic             tx_move, rx_move;
    logic [TOT_W-1:0] remaining;
    logic [CNT_W-1:0] tx_count, rx_count;
    logic [LW-1:0]    acc_lanes;

    assign flush     = start | abort;
    assign acc_lanes = LW'(lanes_of(bus_size));
    assign left      = active && (remaining != '0);

    always_ff @(posedge clk) begin
        if (rst)
            dir_wr <= 1'b0;
        else if (start && !abort)
            dir_wr <= xfer_write;
    end

    cfe_byte_counter #(.LEN_W(LEN_W), .NUM_W(NUM_W)) u_count (
        .clk(clk), .rst(rst), .start(start), .abort(abort),
        .blk_len(blk_len), .blk_cnt(blk_cnt),
        .step(tx_move | rx_move),
        .active(active), .remaining(remaining), .done(done)
    );

    cfe_tx_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_tx (
        .clk(clk), .rst(rst), .flush(flush),
        .bus_wr(bus_wr), .wr_bytes(acc_lanes), .wdata(bus_wdata),
        .pop(tx_move), .head(card_out_data), .count(tx_count)
    );

    cfe_rx_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_rx (
        .clk(clk), .rst(rst), .flush(flush),
        .push(rx_move), .din(card_in_data),
        .bus_rd(bus_rd), .rd_bytes(acc_lanes), .rdata(bus_rdata),
        .count(rx_count)
    );

    assign card_out_valid = left && dir_wr && (tx_count != '0);
    assign card_in_ready  = left && !dir_wr && (rx_count < CNT_W'(DEPTH));
    assign tx_move        = card_out_valid && card_out_ready;
    assign rx_move        = card_in_valid && card_in_ready;

    always_ff @(posedge clk) begin
        if (rst || flush)
            rx_req <= 1'b0;
        else if (rx_move)
            rx_req <= 1'b1;
        else if (bus_rd)
            rx_req <= 1'b0;
    end

    assign busy      = active;
    assign tx_req    = left && dir_wr;
    assign data_done = done;
    assign prog_done = done && dir_wr;

    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (rst)
        !(card_out_valid && card_in_ready)); // R7
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        data_done |-> $past(busy)); // R8
endmodule

// File: tb/card_fifo_engine_test.sv
module card_fifo_engine_test;
    logic        clk = 1'b0;
    logic        rst, start, abort, xfer_write, bus_rd, bus_wr;
    logic [11:0] blk_len;
    logic [15:0] blk_cnt;
    logic [1:0]  bus_size;
    logic [31:0] bus_wdata, bus_rdata;
    logic [7:0]  card_out_data, card_in_data;
    logic        card_out_valid, card_out_ready, card_in_valid, card_in_ready;
    logic        busy, tx_req, rx_req, data_done, prog_done;

    always #2 clk = ~clk;

    card_fifo_engine uut (
        .clk(clk), .rst(rst), .start(start), .abort(abort), .xfer_write(xfer_write),
        .blk_len(blk_len), .blk_cnt(blk_cnt), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .card_out_data(card_out_data), .card_out_valid(card_out_valid),
        .card_out_ready(card_out_ready), .card_in_data(card_in_data),
        .card_in_valid(card_in_valid), .card_in_ready(card_in_ready),
        .busy(busy), .tx_req(tx_req), .rx_req(rx_req),
        .data_done(data_done), .prog_done(prog_done)
    );

    int n_chk = 0, n_fail = 0;
    int n_card, n_done, n_prog;
    logic mon_clr;
    logic [7:0] cap [0:127];

    // Card-side model: records bytes sent, supplies an incrementing byte stream.
    assign card_in_data = 8'hA0 + n_card[7:0];
    always @(posedge clk) begin
        if (mon_clr) begin
            n_card <= 0; n_done <= 0; n_prog <= 0;
        end else begin
            if (card_out_valid && card_out_ready) begin
                cap[n_card & 127] <= card_out_data;
                n_card <= n_card + 1;
            end else if (card_in_valid && card_in_ready) begin
                n_card <= n_card + 1;
            end
            if (data_done) n_done <= n_done + 1;
            if (prog_done) n_prog <= n_prog + 1;
        end
    end

    typedef struct packed {
        logic        wr;
        logic [11:0] len;
        logic [15:0] cnt;
        logic [1:0]  sz;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b1, 12'd4,  16'd2, 2'd2},
        '{1'b1, 12'd6,  16'd1, 2'd1},
        '{1'b1, 12'd3,  16'd3, 2'd0},
        '{1'b0, 12'd8,  16'd5, 2'd3},
        '{1'b0, 12'd5,  16'd2, 2'd1},
        '{1'b0, 12'd7,  16'd1, 2'd0},
        '{1'b1, 12'd20, 16'd3, 2'd2}
    };

    function automatic int nb(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [7:0] txb(input int k);
        return 8'((k * 7 + 3) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic begin_xfer(input logic wr, input logic [11:0] len, input logic [15:0] cnt);
        @(negedge clk);
        mon_clr = 1'b1; start = 1'b1; xfer_write = wr; blk_len = len; blk_cnt = cnt;
        @(negedge clk);
        mon_clr = 1'b0; start = 1'b0;
    endtask

    task automatic push_word(input int first, input int n, input logic [31:0] filler);
        logic [31:0] w;
        w = filler;
        for (int i = 0; i < n; i++) w[(n - 1 - i) * 8 +: 8] = txb(first + i);
        bus_wr = 1'b1; bus_wdata = w; bus_size = (n == 1) ? 2'd0 : (n == 2) ? 2'd1 : 2'd2;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        int total, n, pushed, popped, bad, guard;
        logic [31:0] exp;
        total = int'(v.len) * int'(v.cnt);
        n = nb(v.sz);
        bad = 0;
        card_out_ready = 1'b1; card_in_valid = 1'b1;
        begin_xfer(v.wr, v.len, v.cnt);
        chk(tx_req == v.wr, "R9 tx_req while busy", 32'(tx_req), 32'(v.wr));
        if (v.wr) begin
            pushed = 0; guard = 0;
            while (pushed < total && guard < 2000) begin
                guard++;
                if (32 - (pushed - n_card) >= n) begin
                    push_word(pushed, n, 32'hC3C3_C3C3);
                    pushed += n;
                end else @(negedge clk);
            end
            guard = 0;
            while (n_done == 0 && guard < 200) begin guard++; @(negedge clk); end
            for (int k = 0; k < total; k++) if (cap[k] !== txb(k)) bad++;
            chk(bad == 0 && n_card == total, "R3 write packing order", 32'(n_card), 32'(total));
        end else begin
            popped = 0; guard = 0;
            bus_size = v.sz;
            while (popped < total && guard < 2000) begin
                guard++;
                if (n_card - popped > 0) begin
                    int m;
                    m = (n_card - popped < n) ? n_card - popped : n;
                    exp = '0;
                    for (int i = 0; i < m; i++) exp[(n - 1 - i) * 8 +: 8] = 8'hA0 + 8'(popped + i);
                    bus_rd = 1'b1; #1;
                    if (bus_rdata !== exp) begin
                        bad++;
                        $display("FAIL R5 read packing: actual %h expected %h", bus_rdata, exp);
                    end
                    popped += m;
                    @(negedge clk);
                    bus_rd = 1'b0;
                end else @(negedge clk);
            end
            chk(bad == 0 && popped == total, "R5 read packing order", 32'(popped), 32'(total));
        end
        repeat (3) @(negedge clk);
        chk(n_done == 1 && n_card == total, "R2 byte count and done", 32'(n_card), 32'(total));
        chk(n_prog == int'(v.wr), "R8 prog_done by direction", 32'(n_prog), 32'(v.wr));
        chk(!busy && !tx_req, "R8 idle after done", {30'd0, busy, tx_req}, 32'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; start = 1'b0; abort = 1'b0; xfer_write = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
        blk_len = '0; blk_cnt = '0; bus_size = 2'd2; bus_wdata = '0;
        card_out_ready = 1'b0; card_in_valid = 1'b0; mon_clr = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk({busy, tx_req, rx_req, data_done, prog_done, card_out_valid, card_in_ready} == 7'd0,
            "R1 reset outputs",
            {25'd0, busy, tx_req, rx_req, data_done, prog_done, card_out_valid, card_in_ready}, 32'd0);

        for (int i = 0; i < 7; i++) run_vec(VECS[i]);

        // R4: transmit overflow drops the ninth word
        card_out_ready = 1'b0;
        begin_xfer(1'b1, 12'd40, 16'd1);
        for (int w = 0; w < 8; w++) push_word(w * 4, 4, 32'h0);
        bus_wr = 1'b1; bus_wdata = 32'hEEEE_EEEE; bus_size = 2'd2;
        @(negedge clk);
        bus_wr = 1'b0;
        card_out_ready = 1'b1;
        repeat (40) @(negedge clk);
        begin
            int bad;
            bad = 0;
            for (int k = 0; k < 32; k++) if (cap[k] !== txb(k)) bad++;
            chk(n_card == 32 && bad == 0, "R4 only 32 bytes kept", 32'(n_card), 32'd32);
        end
        chk(busy && !card_out_valid, "R7 valid needs queued byte", {30'd0, busy, card_out_valid}, 32'd2);
        push_word(32, 4, 32'h0);
        repeat (3) @(negedge clk);
        chk(cap[32] == txb(32), "R4 excess word discarded", 32'(cap[32]), 32'(txb(32)));
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk(!busy && !tx_req && !card_out_valid, "R11 abort idles write",
            {29'd0, busy, tx_req, card_out_valid}, 32'd0);

        // R6: receive queue stops at 32 bytes
        card_in_valid = 1'b1;
        begin_xfer(1'b0, 12'd40, 16'd1);
        repeat (45) @(negedge clk);
        chk(n_card == 32 && !card_in_ready, "R6 receive full", 32'(n_card), 32'd32);
        chk(rx_req == 1'b1, "R10 rx_req after store", 32'(rx_req), 32'd1);
        bus_size = 2'd2; bus_rd = 1'b1; #1;
        chk(bus_rdata == 32'hA0A1_A2A3, "R5 word read order", bus_rdata, 32'hA0A1_A2A3);
        @(negedge clk);
        bus_rd = 1'b0; #1;
        chk(card_in_ready == 1'b1, "R6 room reopens", 32'(card_in_ready), 32'd1);
        @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0; #1;
        chk(!busy && !rx_req && !card_in_ready, "R11 abort idles read",
            {29'd0, busy, rx_req, card_in_ready}, 32'd0);
        bus_rd = 1'b1; #1;
        chk(bus_rdata == 32'h0, "R11 queue flushed", bus_rdata, 32'h0);
        @(negedge clk);
        bus_rd = 1'b0;

        // R5/R10: partial read leaves low lanes zero, read clears rx_req
        begin_xfer(1'b0, 12'd2, 16'd1);
        repeat (6) @(negedge clk);
        chk(rx_req == 1'b1 && n_done == 1, "R10 rx_req set", 32'(rx_req), 32'd1);
        bus_size = 2'd2; bus_rd = 1'b1; #1;
        chk(bus_rdata == 32'hA0A1_0000, "R5 short read zero lanes", bus_rdata, 32'hA0A1_0000);
        @(negedge clk);
        bus_size = 2'd1; #1;
        chk(rx_req == 1'b0, "R10 read clears rx_req", 32'(rx_req), 32'd0);
        chk(bus_rdata == 32'h0, "R5 empty read zero", bus_rdata, 32'h0);
        @(negedge clk);
        bus_rd = 1'b0;

        // R12: zero-length write
        card_in_valid = 1'b0;
        begin_xfer(1'b1, 12'd0, 16'd5);
        #1;
        chk(busy && !data_done, "R12 busy one cycle", {30'd0, busy, data_done}, 32'd2);
        @(negedge clk); #1;
        chk(!busy && data_done && prog_done, "R12 immediate done",
            {29'd0, busy, data_done, prog_done}, 32'd3);
        @(negedge clk); #1;
        chk(!data_done && !prog_done, "R8 done lasts one cycle", {30'd0, data_done, prog_done}, 32'd0);

        finish_run();
    end
endmodule